// File: doc/BRIEF.md
# Serial ADC Reader (Host Side)

This block is the host-side controller for a two-channel 8-bit successive-approximation converter that talks over a four-wire serial link: an active-low select, a serial clock driven by the host, a data line into the converter and a data line back. A local client hands over a request carrying a channel number and a single-ended/differential flag through a valid/ready handshake. The reader then runs one complete conversion frame and returns the 8-bit code with a one-cycle done pulse.

Each frame starts with a three-bit address phase: a high start bit, then the input-mode bit, then the channel-select bit. One settling clock follows, during which the converter must hold its output low. Eight code bits come back most significant first. Seven more come back least significant first, starting at bit 1 because bit 0 is not sent again. The reader compares the two copies and flags any disagreement. It also flags a high level seen during the settling clock. The serial clock rate and the select timing guards are derived at elaboration time from the system clock period, so one parameter change retargets the block to another system clock.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, req_ready is 1 and done is 0.
- R2: A request is taken on a cycle with req_valid and req_ready both high. req_ready stays 0 from the next cycle until the frame and the select-high guard are over, and req_valid pulses while req_ready is 0 start no frame and produce no done.
- R3: On di the reader sends 1 (start), then the mode bit (1 = single-ended, that is req_diff = 0), then the channel bit (equal to req_chan), each sampled by the converter on a rising sclk edge. di never changes at a rising sclk edge.
- R4: Every frame has exactly 19 rising sclk edges while cs_n is 0, and sclk is 0 whenever cs_n is 1.
- R5: Each high phase and each low phase of sclk lasts half of one period at the configured rate, clamped to 10 kHz to 600 kHz. With a 10 ns system clock and 500 kHz this is 1000 ns per phase.
- R6: do_in is sampled at the 4th rising edge (settling clock). settle_err reports 1 with done if that sample was 1, else 0.
- R7: result holds the do_in samples at rising edges 5 to 12, the first being bit 7.
- R8: The do_in samples at rising edges 13 to 19 are bits 1 to 7 of the code in that order. mismatch is 1 with done if any of them differs from the same bit of result.
- R9: The first rising sclk edge comes at least 350 ns after cs_n falls, and cs_n stays high at least 220 ns before it falls again.
- R10: done is a one-cycle pulse that comes in the cycle where cs_n has just returned to 1, with result, mismatch and settle_err valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Conversion request present |
| req_ready | output | 1 | Reader idle and able to take a request |
| req_chan | input | 1 | Channel-select bit sent in the address |
| req_diff | input | 1 | 1 = differential input pair, 0 = single-ended |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock to the converter, idles low |
| di | output | 1 | Serial address data to the converter |
| do_in | input | 1 | Serial conversion data from the converter |
| done | output | 1 | One-cycle pulse marking a finished frame |
| result | output | DATA_W | Converted code, MSB-first copy |
| mismatch | output | 1 | MSB-first and LSB-first copies disagree |
| settle_err | output | 1 | Settling clock returned a high level |

## Verification
The hardest conditions to reach are the ones a well-behaved converter never produces: a high level in the settling slot, and an LSB-first echo that disagrees with the MSB-first word in a single bit position. The bench's converter model has two fault knobs, one that drives the settling slot high and one that flips a chosen echo bit. This lets each error flag be shown to react alone and for each end of the echo (bit 1 and bit 7). Request pulses during a busy frame and differential inputs whose difference clips to zero are also driven, so that hold-off and polarity decode are both observed at the ports.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

  // Converter serial timing limits
  localparam int unsigned SCLK_MIN_KHZ = 10;
  localparam int unsigned SCLK_MAX_KHZ = 600;
  localparam int unsigned CS_HIGH_MIN_NS = 220;
  localparam int unsigned SETUP_MIN_NS = 350;

  // Frame layout: start, mode, channel, then one settling clock
  localparam int unsigned ADDR_RISES = 3;
  localparam int unsigned SETTLE_IDX = ADDR_RISES;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_GUARD
  } rd_state_e;

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned clamp_khz(int unsigned khz);
    if (khz < SCLK_MIN_KHZ) return SCLK_MIN_KHZ;
    if (khz > SCLK_MAX_KHZ) return SCLK_MAX_KHZ;
    return khz;
  endfunction

  // System cycles per sclk phase; equal phases give a 50 % duty cycle
  function automatic int unsigned half_cycles(int unsigned khz, int unsigned period_ns);
    int unsigned half_ns;
    half_ns = ceil_div(500000, clamp_khz(khz));
    return max2(1, ceil_div(half_ns, period_ns));
  endfunction

  // Cycles that cover a minimum interval in ns
  function automatic int unsigned guard_cycles(int unsigned ns, int unsigned period_ns);
    return max2(1, ceil_div(ns, period_ns));
  endfunction

  // Frame length in rising edges for a code of the given width
  function automatic int unsigned frame_rises(int unsigned data_w);
    return ADDR_RISES + 1 + data_w + (data_w - 1);
  endfunction

endpackage

// File: rtl/adcr_sclk_gen.sv
module adcr_sclk_gen #(
  parameter int unsigned HALF = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic rise,
  output logic fall
);

  localparam int unsigned CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = en && (cnt == CW'(HALF - 1));
  assign rise = tick && !sclk;
  assign fall = tick && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adcr_capture.sv
module adcr_capture #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise,
  input  logic [IW-1:0]     idx,
  input  logic              do_in,
  output logic [DATA_W-1:0] msb_word,
  output logic [DATA_W-2:0] lsb_echo,
  output logic              settle_bit
);

  import adcr_pkg::*;

  localparam int unsigned MSB_LO = SETTLE_IDX + 1;
  localparam int unsigned MSB_HI = MSB_LO + DATA_W - 1;
  localparam int unsigned LSB_LO = MSB_HI + 1;
  localparam int unsigned LSB_HI = LSB_LO + DATA_W - 2;

  logic in_settle, in_msb, in_lsb;

  assign in_settle = (idx == IW'(SETTLE_IDX));
  assign in_msb    = (idx >= IW'(MSB_LO)) && (idx <= IW'(MSB_HI));
  assign in_lsb    = (idx >= IW'(LSB_LO)) && (idx <= IW'(LSB_HI));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      msb_word   <= '0;
      lsb_echo   <= '0;
      settle_bit <= 1'b0;
    end else if (rise) begin
      if (in_settle) settle_bit <= do_in;
      if (in_msb)    msb_word   <= {msb_word[DATA_W-2:0], do_in};
      // bit 1 arrives first and ends up in lsb_echo[0]
      if (in_lsb)    lsb_echo   <= {do_in, lsb_echo[DATA_W-2:1]};
    end
  end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adcr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SCLK_KHZ      = 250,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_chan,
  input  logic              req_diff,
  output logic              cs_n,
  output logic              sclk,
  output logic              di,
  input  logic              do_in,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              mismatch,
  output logic              settle_err
);

  localparam int unsigned HALF    = half_cycles(SCLK_KHZ, CLK_PERIOD_NS);
  localparam int unsigned SU_CYC  = guard_cycles(SETUP_MIN_NS, CLK_PERIOD_NS);
  localparam int unsigned CSH_CYC = guard_cycles(CS_HIGH_MIN_NS, CLK_PERIOD_NS);
  localparam int unsigned FRAME   = frame_rises(DATA_W);
  localparam int unsigned IW      = $clog2(FRAME + 1);
  localparam int unsigned GW      = $clog2(max2(SU_CYC, CSH_CYC) + 1);

  rd_state_e         state;
  logic [GW-1:0]     gcnt;
  logic [IW-1:0]     rcnt;
  logic              chan_q, diff_q;

  // Named internal events
  logic              accept;
  logic              sclk_en;
  logic              rise, fall;
  logic              frame_last_fall;
  logic              setup_over, guard_over;
  logic              echo_mismatch;
  logic [DATA_W-1:0] msb_word;
  logic [DATA_W-2:0] lsb_echo;
  logic              settle_bit;

  assign req_ready       = (state == ST_IDLE);
  assign accept          = req_valid && req_ready;
  assign sclk_en         = (state == ST_SHIFT);
  assign frame_last_fall = fall && (rcnt == IW'(FRAME));
  assign setup_over      = (gcnt == GW'(SU_CYC - 1));
  assign guard_over      = (gcnt == GW'(CSH_CYC - 1));
  assign echo_mismatch   = (msb_word[DATA_W-1:1] != lsb_echo);

  adcr_sclk_gen #(.HALF(HALF)) u_sclk_gen (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (sclk_en),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  adcr_capture #(.DATA_W(DATA_W), .IW(IW)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .rise      (rise),
    .idx       (rcnt),
    .do_in     (do_in),
    .msb_word  (msb_word),
    .lsb_echo  (lsb_echo),
    .settle_bit(settle_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      gcnt       <= '0;
      rcnt       <= '0;
      chan_q     <= 1'b0;
      diff_q     <= 1'b0;
      cs_n       <= 1'b1;
      di         <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
      mismatch   <= 1'b0;
      settle_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            chan_q <= req_chan;
            diff_q <= req_diff;
            cs_n   <= 1'b0;
            di     <= 1'b1;          // start bit
            gcnt   <= '0;
            rcnt   <= '0;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (setup_over) begin
            gcnt  <= '0;
            state <= ST_SHIFT;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (rise) rcnt <= rcnt + 1'b1;
          if (fall) begin
            if (rcnt == IW'(1))      di <= ~diff_q;  // mode: 1 = single-ended
            else if (rcnt == IW'(2)) di <= chan_q;   // channel select
            else                     di <= 1'b0;
          end
          if (frame_last_fall) begin
            cs_n       <= 1'b1;
            done       <= 1'b1;
            result     <= msb_word;
            mismatch   <= echo_mismatch;
            settle_err <= settle_bit;
            gcnt       <= '0;
            state      <= ST_GUARD;
          end
        end
        ST_GUARD: begin
          if (guard_over) state <= ST_IDLE;
          else            gcnt  <= gcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adcr_checker.sv
module adcr_checker #(
  parameter int unsigned SU_CYC  = 35,
  parameter int unsigned CSH_CYC = 22,
  parameter int unsigned FRAME   = 19
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic di,
  input logic req_ready,
  input logic done
);

  int unsigned low_cnt, high_cnt, rise_cnt;
  logic        sclk_q, cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= 0;
      high_cnt <= CSH_CYC;
      rise_cnt <= 0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) low_cnt <= 0;
      else if (low_cnt < 32'hFFFF) low_cnt <= low_cnt + 1;
      if (!cs_n) high_cnt <= 0;
      else if (high_cnt < 32'hFFFF) high_cnt <= high_cnt + 1;
      if (!cs_n && cs_q) rise_cnt <= 0;
      else if (!cs_n && sclk && !sclk_q) rise_cnt <= rise_cnt + 1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R4
  AST_FRAME_RISES: assert property (@(posedge clk) disable iff (!rst_n) (cs_n && !cs_q) |-> (rise_cnt == FRAME)); // R4
  AST_DI_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(di)); // R3
  AST_READY_OFF_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> !req_ready); // R2
  AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> (low_cnt >= SU_CYC)); // R9
  AST_CS_HIGH_GUARD: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> (high_cnt >= CSH_CYC)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && !cs_q)); // R10

endmodule

bind adc_serial_reader adcr_checker #(
  .SU_CYC (SU_CYC),
  .CSH_CYC(CSH_CYC),
  .FRAME  (FRAME)
) u_adcr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .di       (di),
  .req_ready(req_ready),
  .done     (done)
);

// File: tb/test_adc_serial_reader.sv
`timescale 1ns/1ps
module test_adc_serial_reader;

  localparam int unsigned PERIOD_NS = 10;
  localparam int unsigned RATE_KHZ  = 500;
  localparam real PHASE_NS = 1.0e6 / (2.0 * RATE_KHZ);   // R5: 1000 ns

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_chan = 1'b0, req_diff = 1'b0;
  logic       req_ready, cs_n, sclk, di, done, mismatch, settle_err;
  logic       do_in = 1'b1;
  logic [7:0] result;

  always #5 clk = ~clk;

  adc_serial_reader #(.CLK_PERIOD_NS(PERIOD_NS), .SCLK_KHZ(RATE_KHZ), .DATA_W(8)) i_adc_serial_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_diff(req_diff), .cs_n(cs_n), .sclk(sclk), .di(di),
    .do_in(do_in), .done(done), .result(result), .mismatch(mismatch), .settle_err(settle_err)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [7:0] ch_a0 = 8'd0, ch_a1 = 8'd0;
  bit         inj_settle = 0;
  int         corrupt_k = 0;           // 1..7 flips that echo bit, 0 none
  int         m_rises = 0, m_falls = 0;
  bit         m_sgl, m_odd, m_start_ok;
  logic [7:0] m_code;
  logic       m_sclk_prev = 1'b0;
  realtime    t_csfall, t_last, t_csrise = -1.0;
  real        ph_min, ph_max, su_ns, csh_ns = -1.0;

  function automatic logic [7:0] sub_clip(logic [7:0] p, logic [7:0] n);
    return (p > n) ? p - n : 8'd0;
  endfunction

  always @(negedge cs_n or sclk) begin
    if (sclk !== m_sclk_prev) begin
      m_sclk_prev = sclk;
      if (!cs_n) begin
        if (t_last >= 0.0) begin
          if ($realtime - t_last < ph_min) ph_min = $realtime - t_last;
          if ($realtime - t_last > ph_max) ph_max = $realtime - t_last;
        end
        t_last = $realtime;
        if (sclk) begin
          m_rises++;
          if (m_rises == 1) begin
            m_start_ok = (di === 1'b1);
            su_ns = $realtime - t_csfall;
          end
          if (m_rises == 2) m_sgl = di;
          if (m_rises == 3) begin
            m_odd = di;
            if (m_sgl) m_code = m_odd ? ch_a1 : ch_a0;
            else       m_code = m_odd ? sub_clip(ch_a1, ch_a0) : sub_clip(ch_a0, ch_a1);
          end
        end else begin
          m_falls++;
          if (m_falls == 3) do_in = inj_settle;
          else if (m_falls >= 4 && m_falls <= 11) do_in = m_code[11 - m_falls];
          else if (m_falls >= 12 && m_falls <= 18)
            do_in = m_code[m_falls - 11] ^ (corrupt_k == m_falls - 11);
          else do_in = 1'b1;
        end
      end
    end else if (!cs_n) begin
      m_rises = 0; m_falls = 0; m_start_ok = 0;
      t_csfall = $realtime; t_last = -1.0;
      ph_min = 1.0e9; ph_max = 0.0;
      if (t_csrise >= 0.0) csh_ns = $realtime - t_csrise;
    end
  end

  always @(posedge cs_n) t_csrise = $realtime;

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] code; bit mm; bit se; } exp_t;
  exp_t exp_q[$];
  int   sent = 0, dones = 0;
  bit   prev_done = 0;

  task automatic run_conv(bit chan, bit diff, logic [7:0] a0, logic [7:0] a1, bit se, int ck);
    exp_t e;
    while (!req_ready) @(negedge clk);
    ch_a0 = a0; ch_a1 = a1; inj_settle = se; corrupt_k = ck;
    // R3 decode: mode bit 1 = single-ended; diff with chan 0 makes input 0 positive
    if (!diff) e.code = chan ? a1 : a0;
    else if (!chan) e.code = (a0 > a1) ? a0 - a1 : 8'd0;
    else e.code = (a1 > a0) ? a1 - a0 : 8'd0;
    e.mm = (ck >= 1 && ck <= 7);
    e.se = se;
    exp_q.push_back(e);
    sent++;
    req_chan = chan; req_diff = diff; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (50) @(negedge clk);
    chk(req_ready == 1'b0, "R2", "ready during frame", req_ready, 0);
    req_chan = ~chan; req_valid = 1'b1;     // must be ignored
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(done == 1'b0, "R10", "done width", done, 0);
      prev_done = done;
      if (done) begin
        exp_t e;
        dones++;
        chk(cs_n == 1'b1, "R10", "cs_n high at done", cs_n, 1);
        if (exp_q.size() == 0) chk(0, "R2", "unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(result == e.code, "R7", "result", result, e.code);
          chk(mismatch == e.mm, "R8", "mismatch", mismatch, e.mm);
          chk(settle_err == e.se, "R6", "settle_err", settle_err, e.se);
          chk(m_rises == 19, "R4", "rising edges", m_rises, 19);
          chk(m_start_ok, "R3", "start bit", m_start_ok, 1);
          chk(ph_min == PHASE_NS && ph_max == PHASE_NS, "R5", "phase ns",
              int'(ph_max), int'(PHASE_NS));
          chk(su_ns >= 350.0, "R9", "setup ns", int'(su_ns), 350);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL all watchdog actual=%0d expected=%0d", sent - dones, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n reset", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk reset", sclk, 0);
    chk(req_ready == 1'b1, "R1", "ready reset", req_ready, 1);
    chk(done == 1'b0, "R1", "done reset", done, 0);

    run_conv(0, 0, 8'hA5, 8'h3C, 0, 0);   // single, input 0
    run_conv(1, 0, 8'hA5, 8'h3C, 0, 0);   // single, input 1
    run_conv(0, 1, 8'd200, 8'd50, 0, 0);  // diff: 150
    run_conv(1, 1, 8'd200, 8'd50, 0, 0);  // diff reversed: clips to 0
    run_conv(1, 1, 8'd10, 8'd255, 0, 0);  // diff: 245
    run_conv(0, 0, 8'hFF, 8'h00, 0, 0);
    run_conv(1, 0, 8'hFF, 8'h01, 0, 0);
    run_conv(0, 0, 8'h80, 8'h00, 1, 0);   // settling slot high
    run_conv(0, 0, 8'h5A, 8'h00, 0, 1);   // echo bit 1 flipped
    run_conv(1, 0, 8'h00, 8'hC3, 0, 7);   // echo bit 7 flipped
    run_conv(0, 0, 8'h01, 8'h00, 1, 4);   // both faults together

    while (exp_q.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(dones == sent, "R2", "done count", dones, sent);
    chk(csh_ns >= 220.0, "R9", "cs high ns", int'(csh_ns), 220);
    chk(req_ready == 1'b1 && sclk == 1'b0, "R4", "idle after frames", sclk, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule